// File: doc/BRIEF.md
# Variable-Length Instruction Framer and Classifier

This block sits between an instruction word source and a decode/issue stage. It takes a stream of 32-bit words over a valid/ready handshake and splits it into instructions. Some instructions are one word long. Others are two words long: a header word followed by a 32-bit immediate. For every instruction the block produces one registered bundle. The bundle holds the header fields, the immediate, a category tag, a flag that marks two-word instructions, and an illegal flag.

The length of an instruction is not known from the opcode alone. One control opcode carries an immediate only for some of its modifier values. The framer therefore classifies each header word before it decides where the next instruction starts. An illegal header never takes an immediate, so a bad word costs exactly one word of the stream. Execution, register access, program counter handling and branch resolution happen elsewhere.

Top module: `insn_framer`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1. The next accepted word is taken as a header word.
- R2: For a header word, the output fields are taken from these bits: out_opcode = word[31:24], out_mod = word[23:20], out_flags = word[19:18], out_rd = word[17:13], out_rs1 = word[12:8] and out_rs2 = word[7:3]. Bits 2:0 are dropped.
- R3: Legal headers with opcode 0x30, 0x31, 0x38, 0x39, 0x3C or 0x3D take the next accepted word as out_imm and set out_ext=1. The bundle appears in the cycle after that second word is accepted.
- R4: Opcode 0x3F with modifier 1, 2, 3 or 4 is two words long (out_ext=1). With modifier 0, 5, 6 or 7 it is one word long (out_ext=0).
- R5: An opcode outside 0x00-0x0B, 0x10-0x1F, 0x20-0x2C, 0x30-0x31, 0x38-0x39 and 0x3C-0x3F gives out_illegal=1, out_cat=15 and out_ext=0. The following word is then taken as a new header.
- R6: Some modifier values are out of range and give out_illegal=1 with out_ext=0, with the next word taken as a header: values above 7 for 0x2C and 0x3F, above 4 for the four memory opcodes, above 8 for 0x3E, and above 9 for 0x3C. All other opcodes accept any modifier.
- R7: out_cat encodes the opcode group. 0 is integer 0x00-0x0B, 1 is float 0x10-0x1F, 2 is bitwise 0x20-0x27, 3 is compare 0x28-0x2C, 4 is global memory 0x30-0x31, 5 is local memory 0x38-0x39, 6 is atomic 0x3C-0x3D, 7 is wave 0x3E, 8 is control 0x3F and 15 is invalid.
- R8: While out_valid=1 and out_ready=0, the bundle holds its value and in_ready is 0.
- R9: Between the header and the immediate of a two-word instruction, no bundle is presented.
- R10: A one-word instruction shows out_imm = 0.
- R11: A reset that arrives while the framer waits for an immediate drops the held header. The next word is decoded as a header.
- R12: A one-word instruction's bundle appears in the cycle after its word is accepted. Consecutive one-word instructions stream at one per cycle while out_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_word | input | 32 | Input instruction word |
| in_ready | output | 1 | Framer accepts a word this cycle |
| out_valid | output | 1 | Decoded bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_opcode | output | 8 | Opcode field |
| out_mod | output | 4 | Modifier field |
| out_flags | output | 2 | Flags field |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_imm | output | 32 | Immediate word, 0 for one-word instructions |
| out_cat | output | 4 | Category tag |
| out_ext | output | 1 | Instruction was two words long |
| out_illegal | output | 1 | Opcode hole or modifier out of range |

## Verification
Two events can fall in the same cycle: the consumer draining a held bundle, and the framer accepting the next word, which may be a header or the immediate that completes a pending instruction. The bench provokes this with random input gaps and random out_ready stalls over mixed one-word and two-word streams. It also runs a phase with no gaps or stalls, where every cycle both drains and accepts. Every drained bundle is compared in order against bundles computed from the requirements. A stalled bundle must reappear unchanged in the next cycle.

// File: rtl/insn_framer.sv
module insn_framer (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [3:0]  out_mod,
  output logic [1:0]  out_flags,
  output logic [4:0]  out_rd,
  output logic [4:0]  out_rs1,
  output logic [4:0]  out_rs2,
  output logic [31:0] out_imm,
  output logic [3:0]  out_cat,
  output logic        out_ext,
  output logic        out_illegal
);

  function automatic logic [3:0] group_of(input logic [7:0] op);
    if (op <= 8'h0B)                      return 4'd0;
    else if (op >= 8'h10 && op <= 8'h1F) return 4'd1;
    else if (op >= 8'h20 && op <= 8'h27) return 4'd2;
    else if (op >= 8'h28 && op <= 8'h2C) return 4'd3;
    else if (op == 8'h30 || op == 8'h31) return 4'd4;
    else if (op == 8'h38 || op == 8'h39) return 4'd5;
    else if (op == 8'h3C || op == 8'h3D) return 4'd6;
    else if (op == 8'h3E)                return 4'd7;
    else if (op == 8'h3F)                return 4'd8;
    else                                 return 4'hF;
  endfunction

  function automatic logic mod_in_range(input logic [7:0] op, input logic [3:0] md);
    case (op)
      8'h2C, 8'h3F:                 return md <= 4'd7;
      8'h30, 8'h31, 8'h38, 8'h39:   return md <= 4'd4;
      8'h3E:                        return md <= 4'd8;
      8'h3C:                        return md <= 4'd9;
      default:                      return 1'b1;
    endcase
  endfunction

  function automatic logic takes_imm(input logic [7:0] op, input logic [3:0] md);
    case (op)
      8'h30, 8'h31, 8'h38, 8'h39, 8'h3C, 8'h3D: return 1'b1;
      8'h3F:   return md >= 4'd1 && md <= 4'd4;
      default: return 1'b0;
    endcase
  endfunction

  logic        wait_imm;
  logic [31:0] head;
  logic [31:0] hdr;
  logic [3:0]  hdr_cat;
  logic        hdr_bad;
  logic        hdr_long;
  logic        take;

  assign hdr      = wait_imm ? head : in_word;
  assign hdr_cat  = group_of(hdr[31:24]);
  assign hdr_bad  = (hdr_cat == 4'hF) || !mod_in_range(hdr[31:24], hdr[23:20]);
  assign hdr_long = !hdr_bad && takes_imm(hdr[31:24], hdr[23:20]);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_imm    <= 1'b0;
      head        <= '0;
      out_valid   <= 1'b0;
      out_opcode  <= '0;
      out_mod     <= '0;
      out_flags   <= '0;
      out_rd      <= '0;
      out_rs1     <= '0;
      out_rs2     <= '0;
      out_imm     <= '0;
      out_cat     <= '0;
      out_ext     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (take && !wait_imm && hdr_long) begin
      head      <= in_word;
      wait_imm  <= 1'b1;
      out_valid <= 1'b0;
    end else if (take) begin
      wait_imm    <= 1'b0;
      out_valid   <= 1'b1;
      out_opcode  <= hdr[31:24];
      out_mod     <= hdr[23:20];
      out_flags   <= hdr[19:18];
      out_rd      <= hdr[17:13];
      out_rs1     <= hdr[12:8];
      out_rs2     <= hdr[7:3];
      out_imm     <= wait_imm ? in_word : 32'h0;
      out_cat     <= hdr_cat;
      out_ext     <= wait_imm;
      out_illegal <= !wait_imm && hdr_bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/insn_framer_chk.sv
module insn_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_opcode,
  input logic [3:0]  out_mod,
  input logic [31:0] out_imm,
  input logic [3:0]  out_cat,
  input logic        out_ext,
  input logic        out_illegal,
  input logic        wait_imm
);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_mod)
                                && $stable(out_imm) && $stable(out_cat) && $stable(out_ext));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    wait_imm |-> !out_valid);

  p_hole_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cat == 4'hF |-> out_illegal && !out_ext);

  p_bad_short_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> !out_ext);

  p_ext_ops_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ext |-> out_opcode inside {8'h30, 8'h31, 8'h38, 8'h39, 8'h3C, 8'h3D, 8'h3F});

  p_ctrl_len_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_opcode == 8'h3F && !out_illegal |-> out_ext == (out_mod >= 4'd1 && out_mod <= 4'd4));

  p_base_imm_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ext |-> out_imm == 32'h0);

endmodule

bind insn_framer insn_framer_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_opcode(out_opcode), .out_mod(out_mod), .out_imm(out_imm), .out_cat(out_cat),
  .out_ext(out_ext), .out_illegal(out_illegal), .wait_imm(wait_imm)
);

// File: tb/test_insn_framer.sv
`timescale 1ns/1ps
module test_insn_framer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_opcode;
  logic [3:0]  out_mod;
  logic [1:0]  out_flags;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [31:0] out_imm;
  logic [3:0]  out_cat;
  logic        out_ext, out_illegal;

  int errs = 0;
  int checks = 0;

  logic [31:0] wq[$];
  logic [66:0] eq[$];
  string       tq[$];

  always #2 clk = ~clk;

  insn_framer i_insn_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode), .out_mod(out_mod),
    .out_flags(out_flags), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_imm(out_imm), .out_cat(out_cat), .out_ext(out_ext), .out_illegal(out_illegal)
  );

  wire [66:0] act = {out_opcode, out_mod, out_flags, out_rd, out_rs1, out_rs2,
                     out_imm, out_cat, out_ext, out_illegal};

  function automatic logic [3:0] exp_cat(input logic [7:0] op);
    if (op < 8'h0C) return 4'd0;
    if (op >= 8'h10 && op < 8'h20) return 4'd1;
    if (op >= 8'h20 && op < 8'h28) return 4'd2;
    if (op >= 8'h28 && op < 8'h2D) return 4'd3;
    if (op inside {8'h30, 8'h31}) return 4'd4;
    if (op inside {8'h38, 8'h39}) return 4'd5;
    if (op inside {8'h3C, 8'h3D}) return 4'd6;
    if (op == 8'h3E) return 4'd7;
    if (op == 8'h3F) return 4'd8;
    return 4'd15;
  endfunction

  function automatic logic exp_legal(input logic [7:0] op, input logic [3:0] md);
    if (exp_cat(op) == 4'd15) return 1'b0;
    if (op == 8'h2C || op == 8'h3F) return md < 8;
    if (op inside {8'h30, 8'h31, 8'h38, 8'h39}) return md < 5;
    if (op == 8'h3E) return md < 9;
    if (op == 8'h3C) return md < 10;
    return 1'b1;
  endfunction

  function automatic logic exp_two(input logic [7:0] op, input logic [3:0] md);
    if (!exp_legal(op, md)) return 1'b0;
    if (op == 8'h3F) return md >= 1 && md <= 4;
    return op inside {8'h30, 8'h31, 8'h38, 8'h39, 8'h3C, 8'h3D};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [66:0] a, input logic [66:0] e);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic push_insn(input logic [31:0] w, input logic [31:0] imm);
    logic [7:0] op = w[31:24];
    logic [3:0] md = w[23:20];
    logic two = exp_two(op, md);
    logic ok = exp_legal(op, md);
    string tag;
    wq.push_back(w);
    if (two) wq.push_back(imm);
    eq.push_back({w[31:3], two ? imm : 32'h0, exp_cat(op), two, !ok});
    if (!ok && exp_cat(op) == 4'd15) tag = "R5,R7";
    else if (!ok) tag = "R6";
    else if (op == 8'h3F) tag = "R4,R2";
    else if (two) tag = "R3,R2,R7";
    else tag = "R2,R7,R10,R12";
    tq.push_back(tag);
  endtask

  task automatic run(input int gap, input int stall);
    logic pv = 1'b0, pr = 1'b1;
    logic [66:0] pact = '0;
    int cyc = 0;
    while ((wq.size() > 0 || eq.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      in_valid  = wq.size() > 0 && ($urandom % 100) >= gap;
      in_word   = in_valid ? wq[0] : $urandom;
      out_ready = ($urandom % 100) >= stall;
      #1;
      if (pv && !pr) chk(out_valid && act == pact, "R8 held bundle", act, pact);
      if (out_valid && !out_ready) chk(!in_ready, "R8 in_ready", {66'h0, in_ready}, 67'h0);
      if (out_valid && out_ready) begin
        if (eq.size() == 0) chk(1'b0, "R9 unexpected bundle", act, 67'h0);
        else begin
          chk(act == eq[0], tq[0], act, eq[0]);
          void'(eq.pop_front());
          void'(tq.pop_front());
        end
      end
      if (in_valid && in_ready) void'(wq.pop_front());
      pv = out_valid; pr = out_ready; pact = act;
    end
    if (cyc >= 20000) chk(1'b0, "watchdog R12", 67'h0, 67'h1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rand_insns(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] op = ($urandom % 10 < 8) ? 8'($urandom % 64) : 8'($urandom);
      logic [3:0] md = (op == 8'h3F) ? 4'($urandom % 9) : 4'($urandom);
      push_insn({op, md, 20'($urandom)}, $urandom);
    end
  endtask

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog R12 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R1 reset state", {65'h0, out_valid, in_ready}, 67'h1);

    // directed corners
    push_insn(32'h00_0_2A5F8, 32'h0);
    push_insn(32'h2C_7_11111, 32'h0);
    push_insn(32'h2C_8_11111, 32'hDEAD);
    push_insn(32'h0C_0_00000, 32'hBEEF);
    push_insn(32'h40_3_FFFFF, 32'h1);
    push_insn(32'h30_4_12345, 32'hCAFEF00D);
    push_insn(32'h30_5_12345, 32'h3F100000);
    for (int m = 0; m < 10; m++) push_insn({8'h3F, 4'(m), 20'hABCDE}, 32'h1000 + m);
    push_insn(32'h3E_8_00001, 32'h0);
    push_insn(32'h3E_9_00001, 32'h0);
    push_insn(32'h3C_9_00002, 32'h55AA55AA);
    push_insn(32'h3C_A_00002, 32'h0);
    push_insn(32'h3D_F_00003, 32'hFFFFFFFF);
    push_insn(32'h39_0_00004, 32'h0);
    run(0, 0);

    rand_insns(300); run(30, 40);
    rand_insns(200); run(0, 0);
    rand_insns(200); run(50, 70);

    // R9: nothing presented between header and immediate
    @(negedge clk);
    w = 32'h31_0_12345;
    in_valid = 1'b1; in_word = w; out_ready = 1'b1;
    #1 chk(in_ready, "R9 header accepted", {66'h0, in_ready}, 67'h1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 chk(!out_valid, "R9 no bundle while waiting", {66'h0, out_valid}, 67'h0);
      @(negedge clk);
    end
    wq.push_back(32'h76543210);
    eq.push_back({w[31:3], 32'h76543210, 4'd4, 1'b1, 1'b0});
    tq.push_back("R9,R3 completion");
    run(0, 0);

    // R11: reset drops a pending header
    @(negedge clk);
    in_valid = 1'b1; in_word = 32'h3C_2_00008; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk(!out_valid && in_ready, "R11 after reset", {65'h0, out_valid, in_ready}, 67'h1);
    push_insn(32'h21_0_0F0F8, 32'h0);
    tq[tq.size()-1] = "R11 first word after reset";
    run(0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule